// File: doc/BRIEF.md
# Asynchronous Host Bus Slave with Wait Handshake

This block sits between an asynchronous host bus and the internal register logic of a chip. The host drives an active-low chip select, separate active-low read and write strobes, an 8-bit data bus and a 5-bit register address. The address is made of a global/block-space bit, a 3-bit block number and a pointer/indirect select. No host clock exists. The block passes the strobes through synchronizer chains into its own clock domain. It then runs exactly one register read or register write on a simple internal port and keeps the host waiting through an active-low wait output until it can serve the access.

On a read, the internal port is strobed once, the returned byte is held, and wait is released only when the byte is present on the outgoing data lines. On a write, the address and data seen during the access are kept. They are committed once the end of the access has been synchronized, so the host needs no hold time after its strobe. After every access the block stays in a recovery interval of a fixed number of internal clocks. Wait holds off any access that starts during that interval. An access with both strobes active is dropped, and wait is not asserted for it.

The outgoing data bus is delivered as a value plus an output enable. A pad ring places it in high impedance whenever the enable is low.

Top module: `host_bus_bridge`

## Requirements
- R1: After reset, with no access in progress, `host_wait_n` is high, `host_dout_en`, `reg_we` and `reg_re` are low, and `reg_addr` is 0.
- R2: `host_dout_en` is high exactly while `host_cs_n` and `host_rd_n` are both low. At all other times the data bus is released.
- R3: Each read access (chip select and read strobe low, write strobe high) produces exactly one `reg_re` pulse, however long the strobe is held. `reg_addr` carries the host address packed as bit 4 = global/block select, bits 3:1 = block number, bit 0 = pointer/indirect select.
- R4: `host_wait_n` rises for a read only after `host_dout` holds the `reg_rdata` value returned in the `reg_re` cycle. From idle, it rises at the (SYNC_STAGES+2)-th clock edge after the strobe goes low.
- R5: Each write access produces exactly one `reg_we` pulse. The pulse comes after the strobe end is synchronized and carries the address and data held during the access, even if the host changes them at the moment the strobe rises. From idle, wait is released at the (SYNC_STAGES+1)-th clock edge.
- R6: `host_wait_n` falls without any clock delay when a single-strobe access starts while the block is not ready. It is never low while no single-strobe access is active.
- R7: Once the end of an access has been synchronized, the block spends RECOVERY_CYCLES clocks in recovery. A new access arriving SYNC_STAGES+1 clocks after the previous strobe rose is held by wait for RECOVERY_CYCLES-SYNC_STAGES clocks longer than from idle. Successive `reg_re`/`reg_we` pulses are at least RECOVERY_CYCLES cycles apart.
- R8: An access with both strobes low under chip select produces no `reg_re` or `reg_we`, and `host_wait_n` stays high. A normal access after it is served normally.
- R9: Strobes asserted while `host_cs_n` is high produce no internal pulse, leave `host_wait_n` high and leave `host_dout_en` low.
- R10: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_global | input | 1 | Global (1) or per-block (0) register space |
| host_block | input | 3 | Block number |
| host_ptr_ind | input | 1 | Selects one of the two registers of the space |
| host_din | input | DATA_W | Data from host |
| host_dout | output | DATA_W | Read data towards host |
| host_dout_en | output | 1 | Drive enable for the host data bus |
| host_wait_n | output | 1 | Wait, active low |
| reg_addr | output | 5 | Internal register address |
| reg_wdata | output | DATA_W | Internal write data |
| reg_we | output | 1 | Internal write enable, one cycle |
| reg_re | output | 1 | Internal read enable, one cycle |
| reg_rdata | input | DATA_W | Internal read data, valid in the `reg_re` cycle |

## Verification
The bench builds the block with its defaults: DATA_W = 8, SYNC_STAGES = 2 and RECOVERY_CYCLES = 4. With a recovery longer than the synchronizer depth, a follow-on access started SYNC_STAGES+1 clocks after the previous strobe rose falls inside the recovery window. This lets the exact extra wait length be measured. The short chain keeps the idle wait latencies at 4 clocks for a read and 3 for a write, small enough to compare cycle by cycle. Eight-bit data allows distinct patterns in the write capture test, where data and address flip at the strobe's trailing edge.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

  localparam int BLK_W   = 3;
  localparam int RADDR_W = BLK_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_HOLD,
    ST_WR_OPEN,
    ST_CONFLICT,
    ST_RECOVER
  } hbb_state_e;

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_READ,
    REQ_WRITE,
    REQ_BOTH
  } hbb_req_e;

  typedef struct packed {
    logic             global_sel;
    logic [BLK_W-1:0] block;
    logic             ptr_ind;
  } hbb_addr_t;

  // Kind of access encoded by the three active-low controls.
  function automatic hbb_req_e classify_req(input logic cs_n, input logic rd_n,
                                            input logic wr_n);
    hbb_req_e r;
    if (cs_n) begin
      r = REQ_NONE;
    end else begin
      unique case ({rd_n, wr_n})
        2'b01:   r = REQ_READ;
        2'b10:   r = REQ_WRITE;
        2'b00:   r = REQ_BOTH;
        default: r = REQ_NONE;
      endcase
    end
    return r;
  endfunction

  // Host must be held off when its access kind is not yet ready.
  function automatic logic hold_off(input hbb_req_e req, input logic rd_ready,
                                    input logic wr_ready);
    return ((req == REQ_READ) && !rd_ready) || ((req == REQ_WRITE) && !wr_ready);
  endfunction

  function automatic hbb_addr_t make_addr(input logic g, input logic [BLK_W-1:0] b,
                                          input logic p);
    hbb_addr_t a;
    a.global_sel = g;
    a.block      = b;
    a.ptr_ind    = p;
    return a;
  endfunction

endpackage

// File: rtl/hbb_sync_chain.sv
module hbb_sync_chain #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hbb_recovery_timer.sv
module hbb_recovery_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run_q && (cnt_q == '0);

endmodule

// File: rtl/hbb_access_fsm.sv
module hbb_access_fsm
  import hbb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hbb_req_e          sync_req,
  input  hbb_addr_t         cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              recovery_done,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              rd_ready,
  output logic              wr_ready,
  output logic              timer_start,
  output hbb_addr_t         reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic [DATA_W-1:0] rd_data
);

  hbb_state_e        state_q, state_n;
  hbb_addr_t         wr_addr_hold;
  logic [DATA_W-1:0] wr_data_hold;
  logic              rd_accept;
  logic              wr_commit;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        unique case (sync_req)
          REQ_READ:  state_n = ST_RD_ISSUE;
          REQ_WRITE: state_n = ST_WR_OPEN;
          REQ_BOTH:  state_n = ST_CONFLICT;
          default:   state_n = ST_IDLE;
        endcase
      end
      ST_RD_ISSUE: state_n = ST_RD_HOLD;
      ST_RD_HOLD:  if (sync_req != REQ_READ)  state_n = ST_RECOVER;
      ST_WR_OPEN:  if (sync_req != REQ_WRITE) state_n = ST_RECOVER;
      ST_CONFLICT: if (sync_req == REQ_NONE)  state_n = ST_RECOVER;
      ST_RECOVER:  if (recovery_done)         state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  assign rd_accept   = (state_q == ST_IDLE) && (state_n == ST_RD_ISSUE);
  assign wr_commit   = (state_q == ST_WR_OPEN) && (state_n == ST_RECOVER);
  assign timer_start = (state_q != ST_RECOVER) && (state_n == ST_RECOVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      rd_ready     <= 1'b0;
      wr_ready     <= 1'b0;
      reg_re       <= 1'b0;
      reg_we       <= 1'b0;
      reg_addr     <= '0;
      reg_wdata    <= '0;
      rd_data      <= '0;
      wr_addr_hold <= '0;
      wr_data_hold <= '0;
    end else begin
      state_q  <= state_n;
      rd_ready <= (state_n == ST_RD_HOLD);
      wr_ready <= (state_n == ST_WR_OPEN);
      reg_re   <= rd_accept;
      reg_we   <= wr_commit;
      if ((sync_req == REQ_WRITE) &&
          ((state_q == ST_IDLE) || (state_q == ST_WR_OPEN))) begin
        wr_addr_hold <= cap_addr;
        wr_data_hold <= cap_data;
      end
      if (rd_accept) begin
        reg_addr <= cap_addr;
      end else if (wr_commit) begin
        reg_addr  <= wr_addr_hold;
        reg_wdata <= wr_data_hold;
      end
      if (state_q == ST_RD_ISSUE) rd_data <= reg_rdata;
    end
  end

endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge
  import hbb_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int SYNC_STAGES     = 2,
  parameter int RECOVERY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_global,
  input  logic [2:0]        host_block,
  input  logic              host_ptr_ind,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_en,
  output logic              host_wait_n,
  output logic [4:0]        reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int CAP_W = RADDR_W + DATA_W;

  logic [2:0]       ctl_sync;
  logic [CAP_W-1:0] cap_raw, cap_bus;
  hbb_addr_t        cap_addr, fsm_addr;
  hbb_req_e         sync_req, host_req;
  logic             rd_ready, wr_ready, timer_start, recovery_done;

  // Control strobes: synchronizer chain, idle value all ones.
  hbb_sync_chain #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b111)
  ) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_cs_n, host_rd_n, host_wr_n}),
    .q(ctl_sync)
  );

  // Address and data delayed by the same depth, so each sample lines up
  // with the strobe sample taken at the same edge.
  assign cap_raw = {make_addr(host_global, host_block, host_ptr_ind), host_din};

  hbb_sync_chain #(
    .WIDTH(CAP_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)
  ) u_cap_align (
    .clk(clk), .rst_n(rst_n),
    .d(cap_raw),
    .q(cap_bus)
  );

  assign cap_addr = hbb_addr_t'(cap_bus[CAP_W-1:DATA_W]);
  assign sync_req = classify_req(ctl_sync[2], ctl_sync[1], ctl_sync[0]);

  hbb_access_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sync_req(sync_req),
    .cap_addr(cap_addr),
    .cap_data(cap_bus[DATA_W-1:0]),
    .recovery_done(recovery_done),
    .reg_rdata(reg_rdata),
    .rd_ready(rd_ready),
    .wr_ready(wr_ready),
    .timer_start(timer_start),
    .reg_addr(fsm_addr),
    .reg_wdata(reg_wdata),
    .reg_we(reg_we),
    .reg_re(reg_re),
    .rd_data(host_dout)
  );

  hbb_recovery_timer #(.CYCLES(RECOVERY_CYCLES)) u_recovery (
    .clk(clk), .rst_n(rst_n),
    .start(timer_start),
    .done(recovery_done)
  );

  assign reg_addr = fsm_addr;

  // Host-side outputs react to the raw pins without clock delay.
  assign host_req     = classify_req(host_cs_n, host_rd_n, host_wr_n);
  assign host_wait_n  = !hold_off(host_req, rd_ready, wr_ready);
  assign host_dout_en = !host_cs_n && !host_rd_n;

endmodule

// File: rtl/hbb_checker.sv
module hbb_checker #(
  parameter int DATA_W          = 8,
  parameter int RECOVERY_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              wait_n,
  input logic [DATA_W-1:0] dout,
  input logic              reg_we,
  input logic              reg_re,
  input logic [DATA_W-1:0] reg_rdata
);

  localparam int GAP_W = $clog2(RECOVERY_CYCLES + 1) + 1;

  logic [GAP_W-1:0] since_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (reg_re || reg_we) begin
      since_q <= GAP_W'(1);
      seen_q  <= 1'b1;
    end else if (int'(since_q) < RECOVERY_CYCLES) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_single_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  p_read_data_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> (dout == $past(reg_rdata)));

  p_single_write_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_wait_only_in_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> (!cs_n && (rd_n != wr_n)));

  p_recovery_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_re || reg_we) && seen_q) |-> (int'(since_q) >= RECOVERY_CYCLES));

  p_conflict_no_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && !wr_n) |-> wait_n);

  p_no_dual_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

endmodule

bind host_bus_bridge hbb_checker #(
  .DATA_W(DATA_W), .RECOVERY_CYCLES(RECOVERY_CYCLES)
) u_hbb_checker (
  .clk(clk), .rst_n(rst_n),
  .cs_n(host_cs_n), .rd_n(host_rd_n), .wr_n(host_wr_n),
  .wait_n(host_wait_n), .dout(host_dout),
  .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
);

// File: tb/host_bus_bridge_tb_top.sv
module host_bus_bridge_tb_top;

  localparam int DATA_W          = 8;
  localparam int SYNC_STAGES     = 2;
  localparam int RECOVERY_CYCLES = 4;
  localparam int RD_LAT  = SYNC_STAGES + 2;
  localparam int WR_LAT  = SYNC_STAGES + 1;
  localparam int GAP     = SYNC_STAGES + 1;
  localparam int RD_B2B  = RD_LAT + RECOVERY_CYCLES - (GAP - 1);
  localparam int WR_B2B  = WR_LAT + RECOVERY_CYCLES - (GAP - 1);

  logic clk = 1'b0;
  logic rst_n;
  logic host_cs_n, host_rd_n, host_wr_n, host_global, host_ptr_ind;
  logic [2:0] host_block;
  logic [DATA_W-1:0] host_din, host_dout, reg_wdata, reg_rdata;
  logic host_dout_en, host_wait_n, reg_we, reg_re;
  logic [4:0] reg_addr;

  always #2 clk = ~clk;

  host_bus_bridge #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .RECOVERY_CYCLES(RECOVERY_CYCLES)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_global(host_global), .host_block(host_block), .host_ptr_ind(host_ptr_ind),
    .host_din(host_din), .host_dout(host_dout), .host_dout_en(host_dout_en),
    .host_wait_n(host_wait_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  // Register model behind the internal port.
  logic [7:0] regs [32];
  int re_count, we_count, dual_seen, stray_wait;
  logic [4:0] last_re_addr, last_we_addr;
  logic [7:0] last_we_data;
  int checks, errors;
  bit done;

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 29 + 5);
  endfunction

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= init_val(i);
    end else begin
      if (reg_we) begin
        regs[reg_addr] <= reg_wdata;
        we_count     <= we_count + 1;
        last_we_addr <= reg_addr;
        last_we_data <= reg_wdata;
      end
      if (reg_re) begin
        re_count     <= re_count + 1;
        last_re_addr <= reg_addr;
      end
      if (reg_we && reg_re) dual_seen <= dual_seen + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !host_wait_n && !(!host_cs_n && (host_rd_n != host_wr_n)))
      stray_wait <= stray_wait + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_addr(input logic [4:0] a);
    host_global  = a[4];
    host_block   = a[3:1];
    host_ptr_ind = a[0];
  endtask

  task automatic release_bus(input logic [4:0] a);
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    set_addr(~a);
    host_din = ~host_din;
  endtask

  // Caller stands at a negedge. Ends at a negedge with the bus released.
  task automatic host_read(input logic [4:0] a, input int extra,
                           output logic [7:0] data, output int wcyc);
    set_addr(a);
    host_cs_n = 1'b0; host_rd_n = 1'b0;
    #1;
    check(host_wait_n == 1'b0, "R6", "wait low at read start", host_wait_n, 0);
    wcyc = 0;
    do begin @(negedge clk); wcyc++; end while (!host_wait_n && wcyc < 100);
    data = host_dout;
    check(host_dout_en == 1'b1, "R2", "drive enable during read", host_dout_en, 1);
    repeat (extra) @(negedge clk);
    release_bus(a);
    #1;
    check(host_dout_en == 1'b0, "R2", "drive enable after read", host_dout_en, 0);
    @(negedge clk);
  endtask

  task automatic host_write(input logic [4:0] a, input logic [7:0] d, input int extra,
                            output int wcyc);
    set_addr(a);
    host_din = d;
    host_cs_n = 1'b0; host_wr_n = 1'b0;
    #1;
    check(host_wait_n == 1'b0, "R6", "wait low at write start", host_wait_n, 0);
    check(host_dout_en == 1'b0, "R2", "no drive during write", host_dout_en, 0);
    wcyc = 0;
    do begin @(negedge clk); wcyc++; end while (!host_wait_n && wcyc < 100);
    repeat (extra) @(negedge clk);
    release_bus(a);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(host_wait_n == 1'b1, "R1", "wait after reset", host_wait_n, 1);
    check(host_dout_en == 1'b0, "R1", "drive enable after reset", host_dout_en, 0);
    check(reg_we == 1'b0 && reg_re == 1'b0, "R1", "enables after reset",
          int'({reg_we, reg_re}), 0);
    check(reg_addr == 5'd0, "R1", "reg_addr after reset", reg_addr, 0);
  endtask

  task automatic t_idle_read;
    logic [7:0] d; int w; int re0;
    re0 = re_count;
    host_read(5'b0_101_1, 0, d, w);
    repeat (8) @(negedge clk);
    check(w == RD_LAT, "R4", "idle read wait length", w, RD_LAT);
    check(d == init_val(5'b0_101_1), "R4", "read data", d, init_val(5'b0_101_1));
    check(re_count - re0 == 1, "R3", "read pulses", re_count - re0, 1);
    check(last_re_addr == 5'b0_101_1, "R3", "read address packing", last_re_addr, 11);
  endtask

  task automatic t_write_capture;
    int w; int we0; logic [7:0] d;
    we0 = we_count;
    host_write(5'b1_010_0, 8'hA5, 2, w);
    repeat (8) @(negedge clk);
    check(w == WR_LAT, "R5", "idle write wait length", w, WR_LAT);
    check(we_count - we0 == 1, "R5", "write pulses", we_count - we0, 1);
    check(last_we_addr == 5'b1_010_0, "R5", "write address", last_we_addr, 20);
    check(last_we_data == 8'hA5, "R5", "write data", last_we_data, 165);
    host_read(5'b1_010_0, 0, d, w);
    repeat (8) @(negedge clk);
    check(d == 8'hA5, "R5", "write read-back", d, 165);
  endtask

  task automatic t_long_strobe;
    logic [7:0] d; int w; int re0; int we0;
    re0 = re_count; we0 = we_count;
    host_read(5'b0_111_0, 40, d, w);
    repeat (8) @(negedge clk);
    check(re_count - re0 == 1, "R3", "pulses for long read", re_count - re0, 1);
    host_write(5'b0_001_1, 8'h3C, 40, w);
    repeat (8) @(negedge clk);
    check(we_count - we0 == 1, "R5", "pulses for long write", we_count - we0, 1);
    check(last_we_data == 8'h3C, "R5", "long write data", last_we_data, 60);
  endtask

  task automatic t_back_to_back;
    logic [7:0] d; int w; int re0; int we0;
    re0 = re_count; we0 = we_count;
    host_read(5'b0_000_1, 0, d, w);
    repeat (GAP - 1) @(negedge clk);
    host_read(5'b0_011_0, 0, d, w);
    check(w == RD_B2B, "R7", "follow-on read wait length", w, RD_B2B);
    check(d == init_val(5'b0_011_0), "R7", "follow-on read data", d,
          init_val(5'b0_011_0));
    repeat (8) @(negedge clk);
    check(re_count - re0 == 2, "R7", "follow-on read pulses", re_count - re0, 2);
    host_write(5'b1_110_1, 8'h11, 0, w);
    repeat (GAP - 1) @(negedge clk);
    host_write(5'b1_110_0, 8'h22, 0, w);
    check(w == WR_B2B, "R7", "follow-on write wait length", w, WR_B2B);
    repeat (8) @(negedge clk);
    check(we_count - we0 == 2, "R7", "follow-on write pulses", we_count - we0, 2);
    check(regs[5'b1_110_1] == 8'h11 && regs[5'b1_110_0] == 8'h22, "R7",
          "follow-on write contents", int'({regs[5'b1_110_1], regs[5'b1_110_0]}),
          16'h1122);
  endtask

  task automatic t_conflict;
    int lows; int re0; int we0; logic [7:0] d; int w;
    re0 = re_count; we0 = we_count; lows = 0;
    set_addr(5'b0_010_1);
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_wr_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!host_wait_n) lows++;
    end
    check(lows == 0, "R8", "wait cycles on dual strobe", lows, 0);
    release_bus(5'b0_010_1);
    repeat (12) @(negedge clk);
    check(re_count - re0 == 0 && we_count - we0 == 0, "R8", "pulses on dual strobe",
          (re_count - re0) + (we_count - we0), 0);
    host_read(5'b0_010_1, 0, d, w);
    repeat (8) @(negedge clk);
    check(d == init_val(5'b0_010_1) && w == RD_LAT, "R8", "read after dual strobe",
          w, RD_LAT);
  endtask

  task automatic t_no_select;
    int lows; int ens; int re0; int we0;
    re0 = re_count; we0 = we_count; lows = 0; ens = 0;
    host_cs_n = 1'b1; host_rd_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!host_wait_n) lows++;
      if (host_dout_en) ens++;
    end
    host_rd_n = 1'b1; host_wr_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!host_wait_n) lows++;
    end
    host_wr_n = 1'b1;
    repeat (10) @(negedge clk);
    check(lows == 0, "R9", "wait without select", lows, 0);
    check(ens == 0, "R9", "drive without select", ens, 0);
    check(re_count - re0 == 0 && we_count - we0 == 0, "R9", "pulses without select",
          (re_count - re0) + (we_count - we0), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    re_count = 0; we_count = 0; dual_seen = 0; stray_wait = 0;
    last_re_addr = '0; last_we_addr = '0; last_we_data = '0;
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
    host_global = 1'b0; host_block = '0; host_ptr_ind = 1'b0; host_din = '0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_read();
    t_write_capture();
    t_long_strobe();
    t_back_to_back();
    t_conflict();
    t_no_select();
    check(dual_seen == 0, "R10", "cycles with both enables", dual_seen, 0);
    check(stray_wait == 0, "R6", "wait outside an access", stray_wait, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule